// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Timer

This block decides the cycle in which a MAC transmitter may begin a frame on a shared medium. It watches carrier sense from the PHY, a duplex setting and the MAC's own end-of-frame pulse. From these it times the inter-packet gap before the next frame may start. All gap timing is counted in byte-time ticks, which arrive as a clock-enable input, so one block serves every line rate that uses half-duplex operation (10 and 100 Mbps).

Two gap lengths are programmable. The gap that follows the MAC's own frame uses the back-to-back value. The gap that follows carrier seen on the medium uses the non-back-to-back value. The non-back-to-back gap has two parts. In its first two-thirds, carrier sense sends the block back to deferral, and the gap starts again from zero when carrier falls. In its last third the gap is committed and carrier is ignored. The MAC raises a request, and the block holds that request until it can issue a single-cycle transmit permit. After the permit, the block treats the medium as its own until the MAC reports the frame done.

Top module: `hd_defer_timer`

## Requirements
- R1: While reset is active, and right after it, `tx_permit_o` is low, no request is pending and the medium counts as free with the gap satisfied.
- R2: A request made while the medium is free and the gap is satisfied produces a permit exactly one cycle after the request is sampled. The permit lasts one cycle, and no further permit is issued until `tx_done_i` has been seen.
- R3: When `tx_done_i` is sampled, a back-to-back gap of `ipg_b2b_i` ticks starts. A pending request gets its permit in the cycle after the last of those ticks.
- R4: In half duplex, no permit is given while `crs_i` is high. When carrier falls, a non-back-to-back gap of `ipg_nb2b_i` ticks is timed, and a pending request gets its permit when that gap ends.
- R5: Carrier seen during a non-back-to-back gap, while the count of elapsed ticks is below floor(2×gap/3), returns the block to deferral. A fresh gap then starts from zero when carrier falls.
- R6: Carrier seen during a non-back-to-back gap, once the count of elapsed ticks has reached floor(2×gap/3), is ignored. The permit comes when the original gap ends.
- R7: With `full_duplex_i` high, `crs_i` has no effect: permits and back-to-back gaps behave as if carrier were low.
- R8: A gap value of zero is timed as one tick.
- R9: Gap counters advance only on cycles where `tick_i` is high.
- R10: A request made during deferral, a gap or the block's own transmission is held until it is granted. It is never dropped, and it produces exactly one permit.
- R11: If carrier rises in a cycle where a pending request would otherwise be granted, carrier wins. No permit is issued, and the request waits for a full non-back-to-back gap.
- R12: In half duplex, carrier seen during a back-to-back gap ends that gap and starts carrier deferral. The non-back-to-back gap follows when carrier falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Byte-time enable for the gap counters |
| full_duplex_i | input | 1 | 1 = full duplex, carrier ignored |
| crs_i | input | 1 | Carrier sense from the PHY |
| tx_done_i | input | 1 | Pulse: the MAC's own frame has ended |
| ipg_b2b_i | input | GAP_W | Back-to-back gap in ticks |
| ipg_nb2b_i | input | GAP_W | Non-back-to-back gap in ticks |
| tx_req_i | input | 1 | Pulse: the MAC wants to send a frame |
| tx_permit_o | output | 1 | Single-cycle permit to start the frame |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a grant and a rising carrier. The bench provokes this by raising carrier in the very cycle after a request is latched at an idle medium, and it judges the result by the absence of any permit until one full non-back-to-back gap after carrier falls. The second pair is a restart and a tick. Carrier is pulsed one tick before and exactly at the two-thirds boundary, on a cycle that also carries a tick. The scoreboard's expected permit cycle differs by a whole restarted gap between the two cases.

// File: rtl/hd_defer_pkg.sv
package hd_defer_pkg;
  typedef enum logic [2:0] {
    ST_READY    = 3'd0,
    ST_CARRIER  = 3'd1,
    ST_GAP_B2B  = 3'd2,
    ST_GAP_NB2B = 3'd3,
    ST_BUSY     = 3'd4
  } defer_state_e;
endpackage

// File: rtl/hd_gap_calc.sv
module hd_gap_calc #(
  parameter int GAP_W = 8
) (
  input  logic [GAP_W-1:0] gap_i,
  output logic [GAP_W-1:0] gap_eff_o,
  output logic [GAP_W-1:0] split_o
);
  localparam int XW = GAP_W + 2;

  logic [XW-1:0] twice;

  // zero gap is timed as one tick
  assign gap_eff_o = (gap_i == '0) ? GAP_W'(1) : gap_i;
  assign twice     = XW'(gap_eff_o) << 1;
  assign split_o   = GAP_W'(twice / XW'(3));
endmodule

// File: rtl/hd_gap_counter.sv
module hd_gap_counter #(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [GAP_W-1:0] gap_eff_i,
  input  logic [GAP_W-1:0] split_i,
  output logic             last_tick_o,
  output logic             restartable_o
);
  localparam int CW = GAP_W + 1;

  logic [GAP_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_inc[GAP_W-1:0];
  end

  assign cnt_inc       = {1'b0, cnt_q} + CW'(1);
  assign last_tick_o   = cnt_inc >= {1'b0, gap_eff_i};
  assign restartable_o = cnt_q < split_i;
endmodule

// File: rtl/hd_req_hold.sv
module hd_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= (pend_o & ~take_i) | set_i;
  end
endmodule

// File: rtl/hd_defer_fsm.sv
module hd_defer_fsm
  import hd_defer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic crs_i,
  input  logic tx_done_i,
  input  logic pend_i,
  input  logic last_tick_i,
  input  logic restartable_i,
  output logic cnt_clr_o,
  output logic cnt_adv_o,
  output logic grant_o,
  output logic use_nb2b_o
);
  defer_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_READY;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d      = st_q;
    cnt_clr_o = 1'b0;
    cnt_adv_o = 1'b0;
    grant_o   = 1'b0;
    unique case (st_q)
      ST_READY: begin
        if (crs_i) st_d = ST_CARRIER;
        else if (pend_i) begin
          grant_o = 1'b1;
          st_d    = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (tx_done_i) begin
          st_d      = ST_GAP_B2B;
          cnt_clr_o = 1'b1;
        end
      end
      ST_CARRIER: begin
        if (!crs_i) begin
          st_d      = ST_GAP_NB2B;
          cnt_clr_o = 1'b1;
        end
      end
      ST_GAP_B2B: begin
        if (crs_i) begin
          st_d      = ST_CARRIER;
          cnt_clr_o = 1'b1;
        end else if (tick_i) begin
          if (last_tick_i) st_d = ST_READY;
          else             cnt_adv_o = 1'b1;
        end
      end
      ST_GAP_NB2B: begin
        // restartable part: carrier sends us back to deferral
        if (crs_i && restartable_i) begin
          st_d      = ST_CARRIER;
          cnt_clr_o = 1'b1;
        end else if (tick_i) begin
          if (last_tick_i) st_d = ST_READY;
          else             cnt_adv_o = 1'b1;
        end
      end
      default: st_d = ST_READY;
    endcase
  end

  assign use_nb2b_o = (st_q == ST_GAP_NB2B);
endmodule

// File: rtl/hd_defer_timer.sv
module hd_defer_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             full_duplex_i,
  input  logic             crs_i,
  input  logic             tx_done_i,
  input  logic [GAP_W-1:0] ipg_b2b_i,
  input  logic [GAP_W-1:0] ipg_nb2b_i,
  input  logic             tx_req_i,
  output logic             tx_permit_o
);
  logic             crs_eff;
  logic             pend;
  logic             grant;
  logic             use_nb2b;
  logic             cnt_clr;
  logic             cnt_adv;
  logic             last_tick;
  logic             restartable;
  logic [GAP_W-1:0] gap_sel;
  logic [GAP_W-1:0] gap_eff;
  logic [GAP_W-1:0] split;

  assign crs_eff = crs_i & ~full_duplex_i;
  assign gap_sel = use_nb2b ? ipg_nb2b_i : ipg_b2b_i;

  hd_gap_calc #(.GAP_W(GAP_W)) u_calc (
    .gap_i     (gap_sel),
    .gap_eff_o (gap_eff),
    .split_o   (split)
  );

  hd_gap_counter #(.GAP_W(GAP_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (cnt_clr),
    .adv_i         (cnt_adv),
    .gap_eff_i     (gap_eff),
    .split_i       (split),
    .last_tick_o   (last_tick),
    .restartable_o (restartable)
  );

  hd_req_hold u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tx_req_i),
    .take_i (grant),
    .pend_o (pend)
  );

  hd_defer_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .crs_i         (crs_eff),
    .tx_done_i     (tx_done_i),
    .pend_i        (pend),
    .last_tick_i   (last_tick),
    .restartable_i (restartable),
    .cnt_clr_o     (cnt_clr),
    .cnt_adv_o     (cnt_adv),
    .grant_o       (grant),
    .use_nb2b_o    (use_nb2b)
  );

  assign tx_permit_o = grant;
endmodule

// File: rtl/hd_defer_timer_chk.sv
module hd_defer_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic full_duplex_i,
  input logic crs_i,
  input logic tx_done_i,
  input logic tx_permit_o
);
  logic granted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          granted_q <= 1'b0;
    else if (tx_permit_o) granted_q <= 1'b1;
    else if (tx_done_i)   granted_q <= 1'b0;
  end

  // R2
  permit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_permit_o |=> !tx_permit_o);

  // R2
  no_regrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_q |-> !tx_permit_o);

  // R4
  carrier_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && crs_i) |-> !tx_permit_o);

  // R3
  gap_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_done_i) |-> !tx_permit_o);
endmodule

bind hd_defer_timer hd_defer_timer_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .full_duplex_i (full_duplex_i),
  .crs_i         (crs_i),
  .tx_done_i     (tx_done_i),
  .tx_permit_o   (tx_permit_o)
);

// File: tb/hd_defer_timer_tb_top.sv
`timescale 1ns/1ps
module hd_defer_timer_tb_top;
  localparam int GAP_W = 8;
  localparam int GB = 5;
  localparam int GN = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b1;
  logic             full_duplex_i = 1'b0;
  logic             crs_i = 1'b0;
  logic             tx_done_i = 1'b0;
  logic [GAP_W-1:0] ipg_b2b_i = GAP_W'(GB);
  logic [GAP_W-1:0] ipg_nb2b_i = GAP_W'(GN);
  logic             tx_req_i = 1'b0;
  logic             tx_permit_o;

  typedef struct {
    int unsigned c;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  hd_defer_timer #(.GAP_W(GAP_W)) dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .full_duplex_i (full_duplex_i),
    .crs_i         (crs_i),
    .tx_done_i     (tx_done_i),
    .ipg_b2b_i     (ipg_b2b_i),
    .ipg_nb2b_i    (ipg_nb2b_i),
    .tx_req_i      (tx_req_i),
    .tx_permit_o   (tx_permit_o)
  );

  task automatic expect_at(input int unsigned c, input string tag);
    exp_t e;
    e.c = c;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_req();
    tx_req_i = 1'b1;
    nxt();
    tx_req_i = 1'b0;
  endtask

  task automatic done_gap(input bit pend_exp, input string tag, input int gap);
    tx_done_i = 1'b1;
    if (pend_exp) expect_at(cyc + 1 + gap, tag);
    nxt();
    tx_done_i = 1'b0;
    nxt(gap + 3);
  endtask

  // grant at idle, then queue a second request during the own transmission
  task automatic grant_then_hold(input string tag);
    expect_at(cyc + 1, tag);
    pulse_req();
    nxt(2);
    pulse_req();
    nxt(2);
  endtask

  // monitor: compare each permit against the scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (rst_ni && !ended) begin
        if (q.size() > 0 && q[0].c < cyc) begin
          n_chk++; n_bad++;
          $display("FAIL %s: permit missing, actual none by cycle %0d, expected cycle %0d",
                   q[0].tag, cyc, q[0].c);
          void'(q.pop_front());
        end
        if (tx_permit_o) begin
          n_chk++;
          if (q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: unexpected permit, actual cycle %0d, expected none", cyc);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.c != cyc) begin
              n_bad++;
              $display("FAIL %s: permit actual cycle %0d, expected cycle %0d", e.tag, cyc, e.c);
            end
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R10: watchdog expired, actual hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned e;
    // R1 reset state
    nxt(3);
    n_chk++;
    if (tx_permit_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: permit in reset actual %b expected 0", tx_permit_o);
    end
    rst_ni = 1'b1;
    nxt(2);
    n_chk++;
    if (tx_permit_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: permit after reset actual %b expected 0", tx_permit_o);
    end

    // R2 idle grant, then hold-off while busy
    expect_at(cyc + 1, "R2");
    pulse_req();
    nxt(4);
    done_gap(1'b0, "", GB);

    // R3 and R10: request during own transmission waits for b2b gap
    grant_then_hold("R2");
    done_gap(1'b1, "R3", GB);
    done_gap(1'b0, "", GB);

    // R4 carrier deferral then nb2b gap
    crs_i = 1'b1;
    nxt();
    pulse_req();
    nxt(3);
    crs_i = 1'b0;
    expect_at(cyc + 1 + GN, "R4");
    nxt(GN + 4);
    done_gap(1'b0, "", GB);

    // R5 carrier one tick before the split point restarts the gap
    crs_i = 1'b1;
    nxt();
    pulse_req();
    nxt(2);
    crs_i = 1'b0;
    e = cyc + 1;
    while (cyc != e + 3) nxt();
    crs_i = 1'b1;
    nxt();
    crs_i = 1'b0;
    expect_at(cyc + 1 + GN, "R5");
    nxt(GN + 4);
    done_gap(1'b0, "", GB);

    // R6 carrier exactly at the split point is ignored
    crs_i = 1'b1;
    nxt();
    pulse_req();
    nxt(2);
    crs_i = 1'b0;
    e = cyc + 1;
    expect_at(e + GN, "R6");
    while (cyc != e + 4) nxt();
    crs_i = 1'b1;
    nxt();
    crs_i = 1'b0;
    nxt(GN + 4);
    done_gap(1'b0, "", GB);

    // R7 full duplex: carrier held high has no effect
    full_duplex_i = 1'b1;
    crs_i = 1'b1;
    nxt();
    grant_then_hold("R7");
    done_gap(1'b1, "R7", GB);
    done_gap(1'b0, "", GB);
    crs_i = 1'b0;
    full_duplex_i = 1'b0;
    nxt();

    // R8 zero gap is one tick
    ipg_b2b_i = '0;
    grant_then_hold("R2");
    done_gap(1'b1, "R8", 1);
    done_gap(1'b0, "", 1);
    ipg_b2b_i = GAP_W'(GB);

    // R9 counter advances only on ticks
    ipg_b2b_i = GAP_W'(3);
    tick_i = 1'b0;
    grant_then_hold("R2");
    tx_done_i = 1'b1;
    e = cyc + 1;
    expect_at(e + 8, "R9");
    nxt();
    tx_done_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      while (cyc != e + 1 + 3 * i) nxt();
      tick_i = 1'b1;
      nxt();
      tick_i = 1'b0;
    end
    nxt(4);
    tick_i = 1'b1;
    ipg_b2b_i = GAP_W'(GB);
    done_gap(1'b0, "", GB);

    // R11 carrier in the grant cycle wins
    tx_req_i = 1'b1;
    nxt();
    tx_req_i = 1'b0;
    crs_i = 1'b1;
    nxt(3);
    crs_i = 1'b0;
    expect_at(cyc + 1 + GN, "R11");
    nxt(GN + 4);
    done_gap(1'b0, "", GB);

    // R12 carrier during b2b gap switches to carrier deferral
    grant_then_hold("R2");
    tx_done_i = 1'b1;
    nxt();
    tx_done_i = 1'b0;
    crs_i = 1'b1;
    nxt();
    crs_i = 1'b0;
    expect_at(cyc + 1 + GN, "R12");
    nxt(GN + 4);
    done_gap(1'b0, "", GB);

    nxt(5);
    // R10 nothing left unserved
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: outstanding permits actual %0d expected 0", q.size());
    end
    ended = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule